// File: doc/BRIEF.md
# Operand-Two Barrel Shifter

This block forms the second operand of a data-processing operation, together with the carry the shifter contributes to flag generation. In register form, a 32-bit source value is shifted or rotated. The amount comes either from a 5-bit field in the instruction or from the low byte of a second register. In immediate form, an 8-bit constant is zero-extended and rotated right by twice a 4-bit rotate field. This reaches constants such as 0x1000 or 0x00FF0000 from a 12-bit field.

The result and the carry-out are registered once. A decoder presents the operand fields in one cycle, and the ALU consumes `op2` and `carry_out` in the next. The registered outputs are all the state the block holds.

Top module: `op2_shifter`

## Requirements
- R1: Shift kind code 0 is a logical left shift. For an amount n from 1 to 31, vacated low bits are zero and `carry_out` is source bit 32-n, the last bit shifted out.
- R2: Shift kind code 1 is a logical right shift. For an amount n from 1 to 31, vacated high bits are zero and `carry_out` is source bit n-1.
- R3: Shift kind code 2 is an arithmetic right shift. For an amount n from 1 to 31, vacated high bits copy source bit 31 and `carry_out` is source bit n-1.
- R4: Shift kind code 3 is a rotate right by the amount modulo 32, with bits leaving bit 0 re-entering at bit 31. For a nonzero amount, `carry_out` equals result bit 31, so a nonzero multiple of 32 returns the source unchanged with carry equal to its bit 31.
- R5: Shift kind code 4 is a one-bit rotate through carry, whatever the amount. The result is `{carry_in, src[31:1]}` and `carry_out` is source bit 0.
- R6: When `amt_sel` is 0 the amount is `sh_imm`. When it is 1 the amount is `rs_val[7:0]`, and `rs_val[31:8]` has no effect.
- R7: In register form, with kind codes 0 to 3, an amount of zero passes `rm_val` unchanged and `carry_out` equals `carry_in`.
- R8: For a logical left or logical right shift by exactly 32, the result is zero and `carry_out` is source bit 0 or bit 31 respectively. For amounts above 32 both the result and `carry_out` are zero.
- R9: For an arithmetic right shift by 32 or more, every result bit and `carry_out` equal source bit 31.
- R10: When `imm_form` is 1, the result is `imm12[7:0]` zero-extended and rotated right by 2×`imm12[11:8]`. Kind, amount and `rm_val` have no effect. Fields 0xD40 give 0x00001000 and 0x8FF gives 0x00FF0000.
- R11: In immediate form, `carry_out` equals result bit 31 when `imm12[11:8]` is nonzero, and equals `carry_in` when it is zero.
- R12: Outputs show the function of the inputs sampled at the previous rising clock edge. A synchronous active-low reset sets `op2` and `carry_out` to zero.
- R13: In register form, the unused kind codes 5 to 7 pass `rm_val` unchanged with `carry_out` equal to `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imm_form | input | 1 | 1 selects the rotated 8-bit constant, 0 selects the shifted register |
| imm12 | input | 12 | Rotate field [11:8] and constant [7:0] |
| rm_val | input | 32 | Register value to be shifted |
| rs_val | input | 32 | Register whose low byte may supply the amount |
| amt_sel | input | 1 | 0: amount from `sh_imm`, 1: amount from `rs_val[7:0]` |
| sh_imm | input | 5 | Instruction-encoded shift amount |
| kind | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| carry_in | input | 1 | Current carry flag |
| op2 | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The bound checker tests a set of relations on every cycle, each linking the registered outputs to the inputs of the previous cycle:
- the carry source of left shifts;
- sign propagation for arithmetic shifts, including the saturated case;
- the carry-equals-bit-31 rule for rotates and rotated constants;
- rotate-through-carry;
- zero-amount and reserved-code pass-through;
- zeroing of oversized logical shifts.

The full result values of rotates, the exact boundary at 32 for logical shifts, and the immediate-encoding examples are shown only by the bench's scenarios. The same holds for the irrelevance of `rs_val[31:8]`. The bench compares each clock against a bit-serial model.

// File: rtl/op2_pkg.sv
package op2_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } op2_kind_e;

endpackage

// File: rtl/op2_amt_sel.sv
module op2_amt_sel #(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter int SH_W  = 5
) (
    input  logic             amt_sel,
    input  logic [SH_W-1:0]  sh_imm,
    input  logic [W-1:0]     rs_val,
    output logic [AMT_W-1:0] amt
);
    logic [W-AMT_W-1:0] unused_rs_hi;

    assign unused_rs_hi = rs_val[W-1:AMT_W];

    always_comb begin
        if (amt_sel) begin
            amt = rs_val[AMT_W-1:0];
        end else begin
            amt = {{(AMT_W-SH_W){1'b0}}, sh_imm};
        end
    end
endmodule

// File: rtl/op2_reg_shift.sv
module op2_reg_shift
    import op2_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     src,
    input  logic [AMT_W-1:0] amt,
    input  logic [2:0]       kind,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0]   sh;
    logic              amt_zero;
    logic              amt_eq_w;
    logic              amt_ge_w;
    logic [W:0]        lsl_x;
    logic [W:0]        lsr_x;
    logic signed [W:0] asr_x;
    logic [W-1:0]      ror_v;

    assign sh       = amt[SH_W-1:0];
    assign amt_zero = (amt == '0);
    assign amt_eq_w = (amt == AMT_W'(W));
    assign amt_ge_w = (amt >= AMT_W'(W));

    // The extra bit beside each shifted value catches the last bit shifted out.
    assign lsl_x = {1'b0, src} << sh;
    assign lsr_x = {src, 1'b0} >> sh;
    assign asr_x = $signed({src, 1'b0}) >>> sh;
    assign ror_v = (src >> sh) | (src << (W - int'(sh)));

    always_comb begin
        res  = src;
        cout = cin;
        case (op2_kind_e'(kind))
            SK_LSL: begin
                if (!amt_zero) begin
                    if (!amt_ge_w) begin
                        {cout, res} = lsl_x;
                    end else begin
                        res  = '0;
                        cout = amt_eq_w ? src[0] : 1'b0;
                    end
                end
            end
            SK_LSR: begin
                if (!amt_zero) begin
                    if (!amt_ge_w) begin
                        res  = lsr_x[W:1];
                        cout = lsr_x[0];
                    end else begin
                        res  = '0;
                        cout = amt_eq_w ? src[W-1] : 1'b0;
                    end
                end
            end
            SK_ASR: begin
                if (!amt_zero) begin
                    if (!amt_ge_w) begin
                        res  = asr_x[W:1];
                        cout = asr_x[0];
                    end else begin
                        res  = {W{src[W-1]}};
                        cout = src[W-1];
                    end
                end
            end
            SK_ROR: begin
                if (!amt_zero) begin
                    res  = ror_v;
                    cout = ror_v[W-1];
                end
            end
            SK_RRX: begin
                res  = {cin, src[W-1:1]};
                cout = src[0];
            end
            default: begin
                res  = src;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/op2_imm_rot.sv
module op2_imm_rot #(
    parameter int W     = 32,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [IMM_W+ROT_W-1:0] field,
    input  logic                   cin,
    output logic [W-1:0]           res,
    output logic                   cout
);
    localparam int SH_W = $clog2(W);

    logic [W-1:0]    base;
    logic [ROT_W-1:0] rot;
    logic [SH_W-1:0] sh;

    assign base = {{(W-IMM_W){1'b0}}, field[IMM_W-1:0]};
    assign rot  = field[IMM_W+ROT_W-1:IMM_W];
    assign sh   = SH_W'({rot, 1'b0});

    always_comb begin
        res  = (base >> sh) | (base << (W - int'(sh)));
        cout = (rot != '0) ? res[W-1] : cin;
    end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
    import op2_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   imm_form,
    input  logic [IMM_W+ROT_W-1:0] imm12,
    input  logic [W-1:0]           rm_val,
    input  logic [W-1:0]           rs_val,
    input  logic                   amt_sel,
    input  logic [$clog2(W)-1:0]   sh_imm,
    input  logic [2:0]             kind,
    input  logic                   carry_in,
    output logic [W-1:0]           op2,
    output logic                   carry_out
);
    localparam int SH_W = $clog2(W);

    typedef struct packed {
        logic [W-1:0] res;
        logic         c;
    } op2_out_t;

    op2_out_t         out_d, out_q;
    logic [AMT_W-1:0] amt;
    logic [W-1:0]     reg_res, imm_res;
    logic             reg_c, imm_c;

    op2_amt_sel #(.W(W), .AMT_W(AMT_W), .SH_W(SH_W)) u_amt (
        .amt_sel (amt_sel),
        .sh_imm  (sh_imm),
        .rs_val  (rs_val),
        .amt     (amt)
    );

    op2_reg_shift #(.W(W), .AMT_W(AMT_W)) u_reg (
        .src  (rm_val),
        .amt  (amt),
        .kind (kind),
        .cin  (carry_in),
        .res  (reg_res),
        .cout (reg_c)
    );

    op2_imm_rot #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
        .field (imm12),
        .cin   (carry_in),
        .res   (imm_res),
        .cout  (imm_c)
    );

    always_comb begin
        out_d = out_q;
        if (imm_form) begin
            out_d.res = imm_res;
            out_d.c   = imm_c;
        end else begin
            out_d.res = reg_res;
            out_d.c   = reg_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign op2       = out_q.res;
    assign carry_out = out_q.c;
endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk
    import op2_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   imm_form,
    input logic [IMM_W+ROT_W-1:0] imm12,
    input logic [W-1:0]           rm_val,
    input logic [W-1:0]           rs_val,
    input logic                   amt_sel,
    input logic [$clog2(W)-1:0]   sh_imm,
    input logic [2:0]             kind,
    input logic                   carry_in,
    input logic [W-1:0]           op2,
    input logic                   carry_out
);
    localparam int SH_W = $clog2(W);

    logic [AMT_W-1:0] amt_c;
    logic [SH_W-1:0]  left_out_idx;
    logic             left_out_bit;
    logic             rot_zero;

    assign amt_c        = amt_sel ? rs_val[AMT_W-1:0] : AMT_W'(sh_imm);
    assign left_out_idx = SH_W'(W - int'(amt_c));
    assign left_out_bit = rm_val[left_out_idx];
    assign rot_zero     = (imm12[IMM_W+ROT_W-1:IMM_W] == '0);

    // R1: left shift carry is the last bit shifted out
    p_lsl_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_form && kind == 3'(SK_LSL) && amt_c != '0 && amt_c < AMT_W'(W))
        |=> (carry_out == $past(left_out_bit)) && (op2[0] == 1'b0));

    // R3: arithmetic right keeps the sign bit
    p_asr_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_form && kind == 3'(SK_ASR))
        |=> op2[W-1] == $past(rm_val[W-1]));

    // R4: rotate carry follows result bit 31
    p_ror_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_form && kind == 3'(SK_ROR) && amt_c != '0)
        |=> carry_out == op2[W-1]);

    // R5: rotate through carry
    p_rrx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_form && kind == 3'(SK_RRX))
        |=> (op2 == {$past(carry_in), $past(rm_val[W-1:1])}) && (carry_out == $past(rm_val[0])));

    // R7: zero amount passes value and carry
    p_zero_amt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_form && kind <= 3'(SK_ROR) && amt_c == '0)
        |=> (op2 == $past(rm_val)) && (carry_out == $past(carry_in)));

    // R8: oversized logical shifts give zero
    p_big_logic_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_form && (kind == 3'(SK_LSL) || kind == 3'(SK_LSR)) && amt_c > AMT_W'(W))
        |=> (op2 == '0) && (carry_out == 1'b0));

    // R9: saturated arithmetic shift
    p_big_asr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_form && kind == 3'(SK_ASR) && amt_c >= AMT_W'(W))
        |=> (op2 == {W{$past(rm_val[W-1])}}) && (carry_out == $past(rm_val[W-1])));

    // R10: zero rotate field yields the bare constant
    p_imm_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_form && rot_zero)
        |=> op2 == {{(W-IMM_W){1'b0}}, $past(imm12[IMM_W-1:0])});

    // R11: immediate carry rule
    p_imm_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_form)
        |=> carry_out == ($past(rot_zero) ? $past(carry_in) : op2[W-1]));

    // R13: reserved kind codes pass through
    p_reserved_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_form && kind > 3'(SK_RRX))
        |=> (op2 == $past(rm_val)) && (carry_out == $past(carry_in)));
endmodule

bind op2_shifter op2_shifter_chk #(.W(W), .AMT_W(AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imm_form  (imm_form),
    .imm12     (imm12),
    .rm_val    (rm_val),
    .rs_val    (rs_val),
    .amt_sel   (amt_sel),
    .sh_imm    (sh_imm),
    .kind      (kind),
    .carry_in  (carry_in),
    .op2       (op2),
    .carry_out (carry_out)
);

// File: tb/op2_shifter_tb.sv
module op2_shifter_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        imm_form;
    logic [11:0] imm12;
    logic [31:0] rm_val, rs_val;
    logic        amt_sel;
    logic [4:0]  sh_imm;
    logic [2:0]  kind;
    logic        carry_in;
    logic [31:0] op2;
    logic        carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    op2_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .imm_form(imm_form), .imm12(imm12),
        .rm_val(rm_val), .rs_val(rs_val), .amt_sel(amt_sel), .sh_imm(sh_imm),
        .kind(kind), .carry_in(carry_in), .op2(op2), .carry_out(carry_out)
    );

    // Bit-serial model: one position per loop step.
    function automatic logic [32:0] model(input logic imf, input logic [11:0] i12,
        input logic [31:0] rm, input logic [31:0] rs, input logic asel,
        input logic [4:0] shi, input logic [2:0] k, input logic ci);
        logic [31:0] v;
        logic        c;
        int          n;
        c = ci;
        if (imf) begin
            v = {24'd0, i12[7:0]};
            n = 2 * int'(i12[11:8]);
            for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
            if (i12[11:8] != 4'd0) c = v[31];
            return {c, v};
        end
        if (k == 3'd4) return {rm[0], ci, rm[31:1]};
        n = asel ? int'(rs[7:0]) : int'(shi);
        v = rm;
        if (k > 3'd4 || n == 0) return {ci, rm};
        for (int i = 0; i < n; i++) begin
            case (k)
                3'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
                3'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
                3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: v = {v[0], v[31:1]};
            endcase
        end
        if (k == 3'd3) c = v[31];
        return {c, v};
    endfunction

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got carry=%0b op2=%08h, expected carry=%0b op2=%08h",
                     tag, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic drive(input logic imf, input logic [11:0] i12, input logic [31:0] rm,
        input logic [31:0] rs, input logic asel, input logic [4:0] shi,
        input logic [2:0] k, input logic ci);
        imm_form = imf; imm12 = i12; rm_val = rm; rs_val = rs;
        amt_sel = asel; sh_imm = shi; kind = k; carry_in = ci;
    endtask

    // Apply one vector, then compare one clock later against the model.
    task automatic step(input string tag);
        logic [32:0] exp;
        exp = model(imm_form, imm12, rm_val, rs_val, amt_sel, sh_imm, kind, carry_in);
        @(posedge clk);
        @(negedge clk);
        check(tag, {carry_out, op2}, exp);
    endtask

    // Apply one vector, then compare against a literal value.
    task automatic step_lit(input string tag, input logic [32:0] exp);
        @(posedge clk);
        @(negedge clk);
        check(tag, {carry_out, op2}, exp);
    endtask

    function automatic string tag_of(input logic imf, input logic [2:0] k);
        if (imf) return "R10/R11";
        case (k)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R13";
        endcase
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R12: watchdog expired, got no end of test, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 12'h0FF, 32'hDEADBEEF, 32'h3, 1'b1, 5'd4, 3'd0, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R12 reset", {carry_out, op2}, 33'd0);
        rst_n = 1'b1;

        // R10: encoding examples
        drive(1'b1, 12'hD40, 32'hFFFFFFFF, 32'h0, 1'b0, 5'd3, 3'd2, 1'b1);
        step_lit("R10 0x40 ror 26", {1'b0, 32'h00001000});
        drive(1'b1, 12'h8FF, 32'h12345678, 32'h0, 1'b1, 5'd0, 3'd4, 1'b0);
        step_lit("R10 0xFF ror 16", {1'b0, 32'h00FF0000});
        // R11: carry from bit 31, or carry_in when the rotate field is zero
        drive(1'b1, 12'h103, 32'h0, 32'h0, 1'b0, 5'd0, 3'd0, 1'b0);
        step_lit("R11 rot nonzero", {1'b1, 32'hC0000000});
        drive(1'b1, 12'h0A5, 32'h0, 32'h0, 1'b0, 5'd0, 3'd0, 1'b1);
        step_lit("R11 rot zero", {1'b1, 32'h000000A5});
        // R1, R2, R3
        drive(1'b0, 12'h0, 32'h80000001, 32'h0, 1'b0, 5'd1, 3'd0, 1'b0);
        step_lit("R1 lsl 1", {1'b1, 32'h00000002});
        drive(1'b0, 12'h0, 32'h00000003, 32'h0, 1'b0, 5'd1, 3'd1, 1'b0);
        step_lit("R2 lsr 1", {1'b1, 32'h00000001});
        drive(1'b0, 12'h0, 32'h80000010, 32'h0, 1'b0, 5'd4, 3'd2, 1'b1);
        step_lit("R3 asr 4", {1'b0, 32'hF8000001});
        // R4: rotate, modulo 32
        drive(1'b0, 12'h0, 32'h80000001, 32'h20, 1'b1, 5'd0, 3'd3, 1'b0);
        step_lit("R4 ror 32", {1'b1, 32'h80000001});
        drive(1'b0, 12'h0, 32'h0000000F, 32'h24, 1'b1, 5'd0, 3'd3, 1'b0);
        step_lit("R4 ror 36", {1'b1, 32'hF0000000});
        // R5
        drive(1'b0, 12'h0, 32'h00000003, 32'h0, 1'b0, 5'd7, 3'd4, 1'b1);
        step_lit("R5 rrx", {1'b1, 32'h80000001});
        // R6: amount source and ignored upper bits
        drive(1'b0, 12'h0, 32'h00000001, 32'hABCD0004, 1'b1, 5'd9, 3'd0, 1'b0);
        step_lit("R6 rs low byte", {1'b0, 32'h00000010});
        drive(1'b0, 12'h0, 32'h00000001, 32'h00000010, 1'b0, 5'd3, 3'd0, 1'b0);
        step_lit("R6 sh_imm", {1'b0, 32'h00000008});
        // R7
        drive(1'b0, 12'h0, 32'h00000005, 32'hFFFFFF00, 1'b1, 5'd0, 3'd1, 1'b1);
        step_lit("R7 zero amount", {1'b1, 32'h00000005});
        // R8
        drive(1'b0, 12'h0, 32'h00000001, 32'h20, 1'b1, 5'd0, 3'd0, 1'b0);
        step_lit("R8 lsl 32", {1'b1, 32'h00000000});
        drive(1'b0, 12'h0, 32'h80000000, 32'h20, 1'b1, 5'd0, 3'd1, 1'b0);
        step_lit("R8 lsr 32", {1'b1, 32'h00000000});
        drive(1'b0, 12'h0, 32'hFFFFFFFF, 32'h21, 1'b1, 5'd0, 3'd0, 1'b1);
        step_lit("R8 lsl 33", {1'b0, 32'h00000000});
        // R9
        drive(1'b0, 12'h0, 32'h80000000, 32'hFF, 1'b1, 5'd0, 3'd2, 1'b0);
        step_lit("R9 asr 255", {1'b1, 32'hFFFFFFFF});
        // R13
        drive(1'b0, 12'h0, 32'h13579BDF, 32'h4, 1'b1, 5'd2, 3'd6, 1'b0);
        step_lit("R13 reserved", {1'b0, 32'h13579BDF});

        // Random vectors, compared each clock (R12 latency throughout)
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] rs_r;
            rs_r = $urandom;
            if ((i % 3) != 0) rs_r[7:0] = 8'($urandom_range(0, 40));
            drive(1'($urandom_range(0, 3) == 0), 12'($urandom), $urandom, rs_r,
                  1'($urandom), 5'($urandom), 3'($urandom), 1'($urandom));
            step(tag_of(imm_form, kind));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule